// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block recovers words from a single asynchronous serial line. An idle-high line falls to begin a start bit. Then 8 or 9 data bits follow, least significant first, and a stop bit ends the frame. The bit period comes from an 8-bit divisor and a speed select. The first sets the length of one sample tick. The second sets how many ticks make one bit. Each bit is decided by a majority of three samples taken around its middle. The start bit is checked again at mid-bit, so a short glitch on the line is thrown away and does not begin a frame.

Finished words go into a two-entry buffer. Each entry holds the 8 data bits, the ninth bit and the framing-error status of that word. The oldest entry is always on the read outputs, and a read strobe pops it. An interrupt output stays high while anything is buffered.

If a word finishes while both entries are full, the overrun bit sets. From then on, completed words are discarded until the receive enable is dropped. Words that were already buffered can still be read during that time.

Top module: `serial_rx_buf`

## Requirements
- R1: Reception runs only while `port_en_i`=1, `rx_en_i`=1 and `sync_mode_i`=0. When any of these conditions fails, the receiver returns to idle and the line is ignored.
- R2: One bit lasts (`divisor_i`+1)×16 clock cycles when `fast_i`=1 and (`divisor_i`+1)×64 cycles when `fast_i`=0. A frame is one low start bit, then the data bits least significant first, then one stop bit.
- R3: With `word9_i`=1 a ninth data bit is received after the eighth, and it appears on `bit9_o`. With `word9_i`=0, `bit9_o` reads 0 for that word.
- R4: Each bit is the majority of three samples taken around mid-bit. A low pulse shorter than a quarter bit does not start a frame.
- R5: A stop bit that resolves low sets `ferr_o`=1 for that word only. A high stop bit gives 0.
- R6: `irq_o` is high exactly while at least one word is buffered. It is 0 after reset and falls only after the last buffered word is popped.
- R7: The buffer holds two words in arrival order. A third word that completes while both entries are full sets `ovr_o`=1 and is discarded, and the two stored words stay readable in order.
- R8: While `ovr_o`=1 every completed word is discarded. Driving `rx_en_i`=0 clears `ovr_o` on the next clock, and the buffered words are kept.
- R9: `data_o`, `bit9_o` and `ferr_o` show the oldest buffered word and stay stable until it is popped. `pop_i` pops that word while `irq_o`=1, and it has no effect while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| divisor_i | input | 8 | Tick length minus one, in clock cycles |
| fast_i | input | 1 | 1: 16 ticks per bit, 0: 64 ticks per bit |
| port_en_i | input | 1 | Serial port enable |
| rx_en_i | input | 1 | Receive enable; low clears overrun |
| sync_mode_i | input | 1 | Synchronous-mode select, must be 0 to receive |
| word9_i | input | 1 | 1 selects 9-bit words |
| pop_i | input | 1 | Read strobe that pops the oldest word |
| data_o | output | 8 | Data of the oldest buffered word |
| bit9_o | output | 1 | Ninth bit of the oldest buffered word |
| ferr_o | output | 1 | Framing error of the oldest buffered word |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Buffer non-empty |

## Verification
The bench sends frames with alternating, all-ones, all-zeros and single-bit data patterns. This separates a bit-order fault from a stuck bit. Nine-bit frames with the top bit both set and clear show whether the ninth bit follows the data or is stuck. The same words are repeated at the slow tick rate and at a larger divisor, which exposes a wrong period formula. A low stop bit, a quarter-bit glitch, a frame sent while disabled, and a burst of four frames with no reads in between cover framing, start validation, enabling and overrun, and each of these is told apart from normal reception.

// File: rtl/serial_rx_buf.sv
module serial_rx_buf #(
  parameter int DIV_W    = 8,
  parameter int FAST_OVS = 16,
  parameter int SLOW_OVS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             fast_i,
  input  logic             port_en_i,
  input  logic             rx_en_i,
  input  logic             sync_mode_i,
  input  logic             word9_i,
  input  logic             pop_i,
  output logic [7:0]       data_o,
  output logic             bit9_o,
  output logic             ferr_o,
  output logic             ovr_o,
  output logic             irq_o
);
  localparam int SW = $clog2(SLOW_OVS);
  localparam int EW = 11;

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;
  st_t state;

  logic [1:0]       sync;
  logic             rx_prev;
  logic [DIV_W-1:0] dcnt;
  logic [SW-1:0]    stick;
  logic [1:0]       samp;
  logic [3:0]       bitn;
  logic [8:0]       sh;
  logic [EW-1:0]    mem [2];
  logic             wp, rp;
  logic [1:0]       cnt;

  wire rxs  = sync[1];
  wire run  = port_en_i & rx_en_i & ~sync_mode_i;
  wire tick = (dcnt == divisor_i);
  wire [SW-1:0] last = fast_i ? SW'(FAST_OVS - 1) : SW'(SLOW_OVS - 1);
  wire [SW-1:0] half = fast_i ? SW'(FAST_OVS / 2) : SW'(SLOW_OVS / 2);
  wire maj    = (samp[1] & samp[0]) | (samp[1] & rxs) | (samp[0] & rxs);
  wire decide = tick && (stick == half + SW'(1));
  wire [3:0] nlast = word9_i ? 4'd8 : 4'd7;

  wire done   = run && state == STOP && decide;
  wire full   = (cnt == 2'd2);
  wire push   = done && !ovr_o && !full;
  wire do_pop = pop_i && cnt != 2'd0;
  wire [EW-1:0] word = word9_i ? {~maj, sh[8], sh[7:0]} : {~maj, 1'b0, sh[8:1]};

  assign {ferr_o, bit9_o, data_o} = mem[rp];
  assign irq_o = (cnt != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      rx_prev <= 1'b1;
    end else begin
      sync    <= {sync[0], rx_i};
      rx_prev <= rxs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       dcnt <= '0;
    else if (!run || state == IDLE)   dcnt <= '0;
    else                              dcnt <= tick ? '0 : dcnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      stick <= '0;
      samp  <= 2'b11;
      bitn  <= '0;
      sh    <= '0;
    end else if (!run) begin
      state <= IDLE;
    end else if (state == IDLE) begin
      if (rx_prev && !rxs) begin
        state <= START;
        stick <= '0;
      end
    end else if (tick) begin
      if (stick == half - SW'(1) || stick == half) samp <= {samp[0], rxs};
      if (decide) begin
        case (state)
          START:   if (maj) state <= IDLE;
          DATA:    sh <= {maj, sh[8:1]};
          default: state <= IDLE;
        endcase
      end
      if (stick == last) begin
        stick <= '0;
        if (state == START) begin
          state <= DATA;
          bitn  <= '0;
        end else if (state == DATA) begin
          if (bitn == nlast) state <= STOP;
          else               bitn  <= bitn + 4'd1;
        end
      end else begin
        stick <= stick + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= 1'b0;
      rp  <= 1'b0;
      cnt <= '0;
      mem[0] <= '0;
      mem[1] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= word;
        wp      <= ~wp;
      end
      if (do_pop) rp <= ~rp;
      cnt <= cnt + {1'b0, push} - {1'b0, do_pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ovr_o <= 1'b0;
    else if (!rx_en_i)                 ovr_o <= 1'b0;
    else if (done && full)             ovr_o <= 1'b1;
  end
endmodule

// File: rtl/serial_rx_buf_chk.sv
module serial_rx_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en_i,
  input logic       rx_en_i,
  input logic       pop_i,
  input logic       irq_o,
  input logic       ovr_o,
  input logic [7:0] data_o,
  input logic [1:0] state
);
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en_i |=> state == 2'd0);
  a_r6_irq_falls_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(pop_i));
  a_r7_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> irq_o);
  a_r8_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !ovr_o);
  a_r9_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !pop_i) |=> $stable(data_o));
endmodule

bind serial_rx_buf serial_rx_buf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en_i(port_en_i), .rx_en_i(rx_en_i),
  .pop_i(pop_i), .irq_o(irq_o), .ovr_o(ovr_o), .data_o(data_o), .state(state)
);

// File: tb/tb_serial_rx_buf.sv
`timescale 1ns/1ps
module tb_serial_rx_buf;
  logic clk = 0, rst_n = 0, rx = 1;
  logic [7:0] div = 8'd1;
  logic fast = 1, pen = 1, ren = 1, syn = 0, w9 = 0;
  logic mon_pop = 0, man_pop = 0, mon_en = 1;
  logic [7:0] data; logic b9, fe, ovr, irq;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [10:0] exp_q[$];

  always #2 clk = ~clk;

  serial_rx_buf dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .divisor_i(div), .fast_i(fast),
    .port_en_i(pen), .rx_en_i(ren), .sync_mode_i(syn), .word9_i(w9),
    .pop_i(mon_pop | man_pop), .data_o(data), .bit9_o(b9), .ferr_o(fe),
    .ovr_o(ovr), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bclks();
    return (int'(div) + 1) * (fast ? 16 : 64);
  endfunction

  task automatic send(input logic [8:0] d, input bit stop_b, input bit keep);
    int n = w9 ? 9 : 8;
    if (keep) exp_q.push_back({~stop_b, w9 ? d[8] : 1'b0, d[7:0]});
    rx = 0; repeat (bclks()) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx = d[i]; repeat (bclks()) @(negedge clk);
    end
    rx = stop_b; repeat (bclks()) @(negedge clk);
    rx = 1; repeat (bclks()) @(negedge clk);
  endtask

  task automatic drained(input string req);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !irq, req, exp_q.size(), 0);
  endtask

  task automatic man_read(input logic [10:0] e, input string req);
    chk({fe, b9, data} == e, req, {fe, b9, data}, e);
    man_pop = 1; @(negedge clk); man_pop = 0; @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_pop) mon_pop <= 0;
    else if (mon_en && irq) begin
      if (exp_q.size() == 0) chk(0, "R1 unexpected word", {fe, b9, data}, 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({fe, b9, data} == e, "R2/R3/R5 word", {fe, b9, data}, e);
      end
      mon_pop <= 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!irq && !ovr, "R6 reset", {irq, ovr}, 0);
    rst_n = 1; repeat (4) @(negedge clk);
    // R9 pop on empty ignored
    man_pop = 1; @(negedge clk); man_pop = 0;
    chk(!irq, "R9 empty pop", irq, 0);
    // R2 fast rate patterns
    send(9'h055, 1, 1); send(9'h0AA, 1, 1); send(9'h0FF, 1, 1); send(9'h000, 1, 1); send(9'h001, 1, 1);
    drained("R2 fast");
    // R3 nine-bit words
    w9 = 1; send(9'h1A5, 1, 1); send(9'h05A, 1, 1); w9 = 0;
    drained("R3 ninth bit");
    // R5 framing error then clean word
    send(9'h3C, 0, 1); send(9'hC3, 1, 1);
    drained("R5 framing");
    // R2 slow rate and larger divisor
    fast = 0; div = 0; send(9'h96, 1, 1);
    div = 1; send(9'h69, 1, 1);
    fast = 1; div = 3; send(9'h81, 1, 1); div = 1;
    drained("R2 slow");
    // R4 glitch rejected
    rx = 0; repeat (bclks() / 4) @(negedge clk); rx = 1;
    repeat (bclks() * 14) @(negedge clk);
    chk(!irq, "R4 glitch", irq, 0);
    send(9'h7E, 1, 1); drained("R4 after glitch");
    // R1 disabled paths
    pen = 0; send(9'h12, 1, 0); pen = 1; @(negedge clk);
    chk(!irq, "R1 port off", irq, 0);
    syn = 1; send(9'h34, 1, 0); syn = 0; @(negedge clk);
    chk(!irq, "R1 sync mode", irq, 0);
    ren = 0; send(9'h56, 1, 0); ren = 1; @(negedge clk);
    chk(!irq, "R1 rx off", irq, 0);
    // R7 overrun
    mon_en = 0;
    send(9'h11, 1, 0); send(9'h22, 1, 0);
    chk(irq && !ovr, "R7 two held", {irq, ovr}, 2);
    send(9'h33, 1, 0);
    chk(ovr == 1, "R7 overrun", ovr, 1);
    send(9'h44, 1, 0);
    chk(ovr == 1, "R8 frozen", ovr, 1);
    man_read(11'h011, "R7 first");
    chk(irq == 1, "R6 still high", irq, 1);
    man_read(11'h022, "R7 second");
    chk(!irq, "R8 discarded", irq, 0);
    ren = 0; @(negedge clk); @(negedge clk);
    chk(!ovr, "R8 clear", ovr, 0);
    ren = 1; mon_en = 1;
    send(9'h5C, 1, 1); drained("R8 resumes");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule